// File: doc/BRIEF.md
# Instruction Dispatch Group Former

The block sits behind instruction decode in an in-order superscalar front end. It takes one pre-classified instruction per cycle and packs the instructions into dispatch groups of at most five slots. For each instruction it either places it in the next free slot of the open group, or closes the open group and opens a new one with that instruction in slot 0. A group closes when the incoming instruction would break a rule of the group:
- a per-unit quota is full;
- a single-use resource is already taken;
- the instruction may only lead a group;
- only a branch may take the last slot;
- a branch through the count register would follow a count-register write in the same group.

A branch seals its group. The group is then reported when the next real instruction arrives, or when a flush comes. Pseudo instructions and unused class codes pass through without consuming anything.

Each accepted instruction yields a registered result one cycle later: the accept strobe, the close flag and the slot index. A group-done pulse with the finished group's size comes out at the same time. A synchronous flush, such as a basic-block boundary, ends the open group and clears all group state.

Top module: `dg_former`

## Requirements
- R1: With `in_valid_i` and `in_ready_o` high, a class code that is not pseudo produces `acc_o`=1 in the next cycle, with `slot_o` equal to the slot taken. Slots fill from 0 upward. An idle cycle gives `acc_o`=0, `close_o`=0, `slot_o`=0 and `done_o`=0 in the next cycle.
- R2: A group holds at most 5 instructions. When 4 slots are filled, a branch (code 10) takes slot 4, and any other class closes the group.
- R3: Class codes and their unit quotas:
  - fixed-point ops (code 1) and lead-only fixed-point ops (code 2) share one quota of 2;
  - loads (code 3) and stores (code 4) share one quota of 2;
  - floating-point ops (code 5) have a quota of 2.

  An instruction whose quota is full closes the group.
- R4: A group holds at most one each of condition-register ops (code 6), special-register ops (code 7), vector ALU ops (code 8) and vector permute ops (code 9). A second one of the same kind closes the group.
- R5: Codes 2, 6 and 7 are accepted only into slot 0. If the open group is not empty, they close it.
- R6: After a branch is accepted, the next instruction that is not pseudo closes that group and takes slot 0.
- R7: An instruction with `in_ctr_br_i`=1 closes the group if an earlier instruction of the same group had `in_ctr_wr_i`=1.
- R8: Code 0 and codes 11 to 15 are pseudo. They give `acc_o`=0, `close_o`=0 and `done_o`=0, and leave the group state unchanged.
- R9: On a close, the next cycle shows `close_o`=1, `slot_o`=0 and `done_o`=1, with `done_cnt_o` equal to the closed group's size. The new group starts with all counts and flags cleared, including the count-register write mark.
- R10: While `flush_i` is high, `in_ready_o` is low and no instruction is taken. In the next cycle, `done_o` pulses with the group size if the group was non-empty. Flush and reset both leave an empty group with all counts and flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous group flush |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Instruction can be taken (low during flush) |
| in_cls_i | input | 4 | Instruction class code |
| in_ctr_wr_i | input | 1 | Instruction writes the count register |
| in_ctr_br_i | input | 1 | Instruction branches through the count register |
| acc_o | output | 1 | Instruction placed in a slot |
| close_o | output | 1 | Open group was closed before this instruction |
| slot_o | output | 3 | Slot index given to the instruction |
| done_o | output | 1 | A group finished |
| done_cnt_o | output | 3 | Size of the finished group |

## Verification
All results are registered once:
- `acc_o`, `close_o`, `slot_o`, `done_o` and `done_cnt_o` are due exactly one clock after the edge that takes the instruction or sees the flush;
- `in_ready_o` is combinational and is valid in the same cycle as `flush_i`.

The bench drives inputs on the falling edge. It samples the registered outputs on the following falling edge, one rising edge later. It reads `in_ready_o` before that edge. The group state is never read directly: it shows up only through later slot numbers and done sizes.

// File: rtl/dg_pkg.sv
package dg_pkg;
  localparam int NUM_CNT = 3;  // 0 fixed-point, 1 load/store, 2 floating-point
  localparam int NUM_FLG = 4;  // 0 cond-reg, 1 special-reg, 2 vector alu, 3 vector permute

  typedef enum logic [3:0] {
    CLS_PSEUDO   = 4'd0,
    CLS_FXU      = 4'd1,
    CLS_FXU_LEAD = 4'd2,
    CLS_LOAD     = 4'd3,
    CLS_STORE    = 4'd4,
    CLS_FPU      = 4'd5,
    CLS_CREG     = 4'd6,
    CLS_SREG     = 4'd7,
    CLS_VALU     = 4'd8,
    CLS_VPERM    = 4'd9,
    CLS_BRANCH   = 4'd10
  } dg_cls_e;

  typedef struct packed {
    logic               pseudo;
    logic               br;
    logic               lead;
    logic [NUM_CNT-1:0] cnt_use;
    logic [NUM_FLG-1:0] flg_use;
  } dg_dec_t;
endpackage

// File: rtl/dg_class_dec.sv
module dg_class_dec
  import dg_pkg::*;
(
  input  logic [3:0] cls_i,
  output dg_dec_t    dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (cls_i)
      CLS_FXU:      dec_o.cnt_use[0] = 1'b1;
      CLS_FXU_LEAD: begin dec_o.cnt_use[0] = 1'b1; dec_o.lead = 1'b1; end
      CLS_LOAD,
      CLS_STORE:    dec_o.cnt_use[1] = 1'b1;
      CLS_FPU:      dec_o.cnt_use[2] = 1'b1;
      CLS_CREG:     begin dec_o.flg_use[0] = 1'b1; dec_o.lead = 1'b1; end
      CLS_SREG:     begin dec_o.flg_use[1] = 1'b1; dec_o.lead = 1'b1; end
      CLS_VALU:     dec_o.flg_use[2] = 1'b1;
      CLS_VPERM:    dec_o.flg_use[3] = 1'b1;
      CLS_BRANCH:   dec_o.br = 1'b1;
      default:      dec_o.pseudo = 1'b1;  // pseudo and unused codes
    endcase
  end
endmodule

// File: rtl/dg_hazard.sv
module dg_hazard
  import dg_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int UNIT_QUOTA  = 2,
  localparam int UW = $clog2(GROUP_SLOTS + 1),
  localparam int CW = $clog2(UNIT_QUOTA + 1)
) (
  input  dg_dec_t                    dec_i,
  input  logic                       ctr_br_i,
  input  logic [UW-1:0]              used_i,
  input  logic [NUM_CNT-1:0][CW-1:0] cnt_i,
  input  logic [NUM_FLG-1:0]         flg_i,
  input  logic                       ctr_set_i,
  input  logic                       sealed_i,
  output logic                       close_o
);
  logic [NUM_CNT-1:0] quota_full;
  logic               flag_hit, lead_hit, last_hit, ctr_hit, nonempty;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_quota
    assign quota_full[k] = dec_i.cnt_use[k] && (cnt_i[k] == CW'(UNIT_QUOTA));
  end

  assign nonempty = (used_i != '0);
  assign flag_hit = |(dec_i.flg_use & flg_i);
  assign lead_hit = dec_i.lead && nonempty;
  assign last_hit = (used_i >= UW'(GROUP_SLOTS - 1)) && !dec_i.br;
  assign ctr_hit  = ctr_set_i && ctr_br_i;

  assign close_o = nonempty &&
                   (sealed_i || (|quota_full) || flag_hit || lead_hit || last_hit || ctr_hit);
endmodule

// File: rtl/dg_group_state.sv
module dg_group_state
  import dg_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int UNIT_QUOTA  = 2,
  localparam int UW = $clog2(GROUP_SLOTS + 1),
  localparam int CW = $clog2(UNIT_QUOTA + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       take_i,
  input  logic                       close_i,
  input  dg_dec_t                    dec_i,
  input  logic                       ctr_wr_i,
  output logic [UW-1:0]              used_o,
  output logic [NUM_CNT-1:0][CW-1:0] cnt_o,
  output logic [NUM_FLG-1:0]         flg_o,
  output logic                       ctr_set_o,
  output logic                       sealed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_o    <= '0;
      ctr_set_o <= 1'b0;
      sealed_o  <= 1'b0;
    end else if (flush_i) begin
      used_o    <= '0;
      ctr_set_o <= 1'b0;
      sealed_o  <= 1'b0;
    end else if (take_i) begin
      used_o    <= close_i ? UW'(1) : used_o + UW'(1);
      ctr_set_o <= (ctr_set_o && !close_i) || ctr_wr_i;
      sealed_o  <= dec_i.br;
    end
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[k] <= '0;
      else if (flush_i)  cnt_o[k] <= '0;
      else if (take_i)   cnt_o[k] <= (close_i ? '0 : cnt_o[k]) + CW'(dec_i.cnt_use[k]);
    end

    a_r3_quota_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o[k] <= CW'(UNIT_QUOTA));
  end

  for (genvar f = 0; f < NUM_FLG; f++) begin : g_flg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flg_o[f] <= 1'b0;
      else if (flush_i)  flg_o[f] <= 1'b0;
      else if (take_i)   flg_o[f] <= (flg_o[f] && !close_i) || dec_i.flg_use[f];
    end

    // R4: a single-use resource is never taken twice without a close in between
    a_r4_single_use : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && flg_o[f] && dec_i.flg_use[f]) |-> close_i);
  end

  a_r2_slot_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_o <= UW'(GROUP_SLOTS));

  a_r10_flush_empty : assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (used_o == '0 && !sealed_o && !ctr_set_o));
endmodule

// File: rtl/dg_former.sv
module dg_former
  import dg_pkg::*;
#(
  parameter int GROUP_SLOTS = 5,
  parameter int UNIT_QUOTA  = 2,
  localparam int UW = $clog2(GROUP_SLOTS + 1),
  localparam int CW = $clog2(UNIT_QUOTA + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [3:0]    in_cls_i,
  input  logic          in_ctr_wr_i,
  input  logic          in_ctr_br_i,
  output logic          acc_o,
  output logic          close_o,
  output logic [UW-1:0] slot_o,
  output logic          done_o,
  output logic [UW-1:0] done_cnt_o
);
  dg_dec_t                    dec;
  logic                       take, close;
  logic [UW-1:0]              used;
  logic [NUM_CNT-1:0][CW-1:0] cnt;
  logic [NUM_FLG-1:0]         flg;
  logic                       ctr_set, sealed;

  assign in_ready_o = !flush_i;
  assign take       = in_valid_i && in_ready_o && !dec.pseudo;

  dg_class_dec u_dec (
    .cls_i (in_cls_i),
    .dec_o (dec)
  );

  dg_hazard #(.GROUP_SLOTS(GROUP_SLOTS), .UNIT_QUOTA(UNIT_QUOTA)) u_haz (
    .dec_i     (dec),
    .ctr_br_i  (in_ctr_br_i),
    .used_i    (used),
    .cnt_i     (cnt),
    .flg_i     (flg),
    .ctr_set_i (ctr_set),
    .sealed_i  (sealed),
    .close_o   (close)
  );

  dg_group_state #(.GROUP_SLOTS(GROUP_SLOTS), .UNIT_QUOTA(UNIT_QUOTA)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .take_i    (take),
    .close_i   (close),
    .dec_i     (dec),
    .ctr_wr_i  (in_ctr_wr_i),
    .used_o    (used),
    .cnt_o     (cnt),
    .flg_o     (flg),
    .ctr_set_o (ctr_set),
    .sealed_o  (sealed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o      <= 1'b0;
      close_o    <= 1'b0;
      slot_o     <= '0;
      done_o     <= 1'b0;
      done_cnt_o <= '0;
    end else begin
      acc_o      <= take;
      close_o    <= take && close;
      slot_o     <= (take && !close) ? used : '0;
      done_o     <= (flush_i && used != '0) || (take && close);
      done_cnt_o <= (flush_i || (take && close)) ? used : '0;
    end
  end

  a_r5_lead_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && dec.lead) |=> (slot_o == '0));

  a_r2_last_branch : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && slot_o == UW'(GROUP_SLOTS - 1)) |-> $past(dec.br));

  a_r9_close_done : assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> (done_o && slot_o == '0 && done_cnt_o != '0));

  a_r8_pseudo_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dec.pseudo && !flush_i) |=> (!acc_o && !done_o));

  a_r6_sealed_close : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sealed && take) |=> close_o);
endmodule

// File: tb/tb_dg_former.sv
`timescale 1ns/1ps
module tb_dg_former;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, valid = 1'b0, wr = 1'b0, br = 1'b0;
  logic [3:0] cls = 4'd0;
  logic       ready, acc, cls_o, done;
  logic [2:0] slot, dcnt;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  dg_former dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .in_valid_i(valid),
    .in_ready_o(ready), .in_cls_i(cls), .in_ctr_wr_i(wr), .in_ctr_br_i(br),
    .acc_o(acc), .close_o(cls_o), .slot_o(slot), .done_o(done), .done_cnt_o(dcnt)
  );

  // {req[19:16], valid, cls[3:0], wr, br, acc, close, slot[2:0], done, cnt[2:0]}
  localparam int NV = 35;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b0,3'd0,1'b0,3'd0},
    {4'd1, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd3, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd2},
    {4'd3, 1'b1,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd3, 1'b1,4'd4,1'b0,1'b0, 1'b1,1'b0,3'd2,1'b0,3'd0},
    {4'd3, 1'b1,4'd3,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd3},
    {4'd3, 1'b1,4'd5,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd3, 1'b1,4'd5,1'b0,1'b0, 1'b1,1'b0,3'd2,1'b0,3'd0},
    {4'd3, 1'b1,4'd5,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd3},
    {4'd5, 1'b1,4'd6,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd1},
    {4'd4, 1'b1,4'd6,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd1},
    {4'd4, 1'b1,4'd8,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd4, 1'b1,4'd9,1'b0,1'b0, 1'b1,1'b0,3'd2,1'b0,3'd0},
    {4'd8, 1'b1,4'd0,1'b0,1'b0, 1'b0,1'b0,3'd0,1'b0,3'd0},
    {4'd4, 1'b1,4'd8,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd3},
    {4'd1, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd1, 1'b1,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd2,1'b0,3'd0},
    {4'd1, 1'b1,4'd5,1'b0,1'b0, 1'b1,1'b0,3'd3,1'b0,3'd0},
    {4'd2, 1'b1,4'd5,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd4},
    {4'd2, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd2, 1'b1,4'd3,1'b0,1'b0, 1'b1,1'b0,3'd2,1'b0,3'd0},
    {4'd2, 1'b1,4'd4,1'b0,1'b0, 1'b1,1'b0,3'd3,1'b0,3'd0},
    {4'd2, 1'b1,4'd10,1'b0,1'b0,1'b1,1'b0,3'd4,1'b0,3'd0},
    {4'd6, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd5},
    {4'd6, 1'b1,4'd10,1'b0,1'b0,1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd6, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd2},
    {4'd5, 1'b1,4'd7,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd1},
    {4'd7, 1'b1,4'd1,1'b1,1'b0, 1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd7, 1'b1,4'd10,1'b0,1'b1,1'b1,1'b1,3'd0,1'b1,3'd2},
    {4'd6, 1'b1,4'd2,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd1},
    {4'd5, 1'b1,4'd2,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd1},
    {4'd8, 1'b1,4'd12,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,3'd0},
    {4'd7, 1'b1,4'd10,1'b0,1'b1,1'b1,1'b0,3'd1,1'b0,3'd0},
    {4'd1, 1'b0,4'd1,1'b0,1'b0, 1'b0,1'b0,3'd0,1'b0,3'd0},
    {4'd9, 1'b1,4'd1,1'b0,1'b0, 1'b1,1'b1,3'd0,1'b1,3'd2}
  };

  function automatic string rq(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic a, input logic c,
                         input logic [2:0] s, input logic d, input logic [2:0] n);
    chk(tag, "acc", int'(acc), int'(a));
    chk(tag, "close", int'(cls_o), int'(c));
    chk(tag, "slot", int'(slot), int'(s));
    chk(tag, "done", int'(done), int'(d));
    chk(tag, "done_cnt", int'(dcnt), int'(n));
  endtask

  task automatic drive(input logic v, input logic [3:0] c, input logic w, input logic b);
    valid = v; cls = c; wr = w; br = b;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk_out("R10", 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    chk("R10", "ready", int'(ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15], VEC[i][14:11], VEC[i][10], VEC[i][9]);
      @(negedge clk);
      chk_out(rq(int'(VEC[i][19:16])), VEC[i][8], VEC[i][7], VEC[i][6:4], VEC[i][3], VEC[i][2:0]);
    end

    // group now holds one FXU; add a count-register writer
    drive(1'b1, 4'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk_out("R7", 1'b1, 1'b0, 3'd1, 1'b0, 3'd0);

    // R10: flush with a valid instruction present; it is not taken
    flush = 1'b1; drive(1'b1, 4'd1, 1'b0, 1'b0);
    #1 chk("R10", "ready", int'(ready), 0);
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b0, 3'd0, 1'b1, 3'd2);
    flush = 1'b0;

    // R10: flush cleared the count-register write mark
    drive(1'b1, 4'd10, 1'b0, 1'b1);
    @(negedge clk);
    chk_out("R10", 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);

    // R10: flush a sealed one-entry group, then flush an empty group
    drive(1'b0, 4'd0, 1'b0, 1'b0); flush = 1'b1;
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b0, 3'd0, 1'b1, 3'd1);
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    flush = 1'b0;

    // R10: reset in the middle of a group
    drive(1'b1, 4'd1, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_out("R1", 1'b1, 1'b0, 3'd1, 1'b0, 3'd0);
    drive(1'b0, 4'd0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R10", 1'b0, 1'b0, 3'd0, 1'b0, 3'd0);
    rst_n = 1'b1;
    drive(1'b1, 4'd6, 1'b0, 1'b0);
    @(negedge clk);
    chk_out("R10", 1'b1, 1'b0, 3'd0, 1'b0, 3'd0);
    drive(1'b0, 4'd0, 1'b0, 1'b0);
    @(negedge clk);

    finish_run();
  end
endmodule